// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block sits between the sample datapath and the analog current cells of a 12-bit converter that is split into a 6-bit unary segment and a 6-bit binary segment. Each sample is an offset-binary code, where 0x000 is the lowest output level and 0xFFF the highest. The upper six bits select how many of 63 equal-weight current cells are switched on. The lower six bits drive six binary-weighted cells directly.

The unary decode is done in two pipelined stages. The first stage turns the three top bits into a row thermometer and the next three bits into a column thermometer. The second stage merges them into 63 enables. The binary bits travel through a matching two-register delay line. A last retiming register then captures all 69 switch controls on one clock edge, so the unary and binary switch edges line up. A valid flag travels with each sample. When no valid sample arrives, the output register keeps its previous contents.

Top module: `dac_seg_decoder`

## Requirements
- R1: While reset is asserted, `unary_o`, `binary_o` and `out_vld_o` are all zero.
- R2: For a valid sample whose upper six bits have the value N, line k of `unary_o` is high exactly when k < N. Exactly N of the 63 lines are high, and they fill up from bit 0.
- R3: A sample presented with `din_vld_i` high before clock edge m appears on the outputs after edge m+2, with `out_vld_o` high. This is a fixed latency of three registers for every bit.
- R4: For a valid sample, `binary_o` equals the lower six bits `din_i[5:0]`, delivered in the same cycle as the matching unary lines.
- R5: When `din_vld_i` is low, `din_i` is ignored. Three edges later `out_vld_o` is low and `unary_o` and `binary_o` keep the values of the last valid sample.
- R6: Code 0x000 gives all unary lines and all binary lines low. Code 0xFFF gives all 63 unary lines high and `binary_o` equal to 6'h3F.
- R7: Valid samples on consecutive cycles are all delivered, one per cycle, in their input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 12 | Offset-binary sample |
| din_vld_i | input | 1 | Sample qualifier |
| unary_o | output | 63 | Equal-weight cell enables, thermometer coded |
| binary_o | output | 6 | Binary-weighted cell enables |
| out_vld_o | output | 1 | High when the outputs were loaded with a new sample on the last edge |

## Verification
The assertions assume that `din_vld_i` and `din_i` have known values on every clock edge after reset. They also assume that reset is held across at least one edge, so the internal cycle counter starts from a clean state. The bench changes inputs only on the falling clock edge and drives valid low with changing data through idle gaps, so the hold behaviour is tested with live data on the input. It sweeps all 4096 codes back to back, then applies a gated pattern driven by a shift register, comparing each cycle against a three-deep model of the pipeline.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
    localparam int DEF_MSB_W = 6;
    localparam int DEF_LSB_W = 6;
    localparam int PIPE_DEPTH = 3;
endpackage

// File: rtl/seg_msb_predecode.sv
module seg_msb_predecode #(
    parameter  int MSB_W = 6,
    localparam int COL_W = MSB_W / 2,
    localparam int ROW_W = MSB_W - COL_W,
    localparam int ROWS  = 1 << ROW_W,
    localparam int COLS  = 1 << COL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [MSB_W-1:0] msb_i,
    input  logic             vld_i,
    output logic [ROWS-1:0]  row_gt_o,
    output logic [ROWS-1:0]  row_eq_o,
    output logic [COLS-1:0]  col_gt_o
);
    typedef struct packed {
        logic [ROWS-1:0] row_gt;
        logic [ROWS-1:0] row_eq;
        logic [COLS-1:0] col_gt;
    } pre_t;

    pre_t pre_d, pre_q;
    int   row_val;
    int   col_val;

    always_comb begin
        pre_d   = pre_q;
        row_val = int'(msb_i[MSB_W-1 -: ROW_W]);
        col_val = int'(msb_i[COL_W-1:0]);
        if (vld_i) begin
            for (int r = 0; r < ROWS; r++) begin
                pre_d.row_gt[r] = (row_val > r);
                pre_d.row_eq[r] = (row_val == r);
            end
            for (int c = 0; c < COLS; c++) begin
                pre_d.col_gt[c] = (col_val > c);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    assign row_gt_o = pre_q.row_gt;
    assign row_eq_o = pre_q.row_eq;
    assign col_gt_o = pre_q.col_gt;
endmodule

// File: rtl/seg_unary_merge.sv
module seg_unary_merge #(
    parameter  int ROWS  = 8,
    parameter  int COLS  = 8,
    localparam int UNARY = ROWS * COLS - 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ROWS-1:0]  row_gt_i,
    input  logic [ROWS-1:0]  row_eq_i,
    input  logic [COLS-1:0]  col_gt_i,
    input  logic             vld_i,
    output logic [UNARY-1:0] therm_o
);
    logic [UNARY-1:0] therm_d, therm_q;

    always_comb begin
        therm_d = therm_q;
        if (vld_i) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (r * COLS + c < UNARY) begin
                        therm_d[r * COLS + c] = row_gt_i[r] | (row_eq_i[r] & col_gt_i[c]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) therm_q <= '0;
        else         therm_q <= therm_d;
    end

    assign therm_o = therm_q;
endmodule

// File: rtl/seg_delay_line.sv
module seg_delay_line #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WIDTH-1:0]  dat_i,
    input  logic              vld_i,
    output logic [WIDTH-1:0]  dat_o,
    output logic [STAGES-1:0] vld_o
);
    logic [WIDTH-1:0]  dat_d [STAGES];
    logic [WIDTH-1:0]  dat_q [STAGES];
    logic [STAGES-1:0] vld_d, vld_q;

    always_comb begin
        for (int s = 0; s < STAGES; s++) begin
            dat_d[s] = dat_q[s];
        end
        vld_d[0] = vld_i;
        if (vld_i) dat_d[0] = dat_i;
        for (int s = 1; s < STAGES; s++) begin
            vld_d[s] = vld_q[s-1];
            if (vld_q[s-1]) dat_d[s] = dat_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) dat_q[s] <= '0;
            vld_q <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) dat_q[s] <= dat_d[s];
            vld_q <= vld_d;
        end
    end

    assign dat_o = dat_q[STAGES-1];
    assign vld_o = vld_q;
endmodule

// File: rtl/dac_seg_decoder.sv
module dac_seg_decoder
    import dac_seg_pkg::*;
#(
    parameter  int MSB_W  = DEF_MSB_W,
    parameter  int LSB_W  = DEF_LSB_W,
    localparam int DATA_W = MSB_W + LSB_W,
    localparam int UNARY  = (1 << MSB_W) - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] din_i,
    input  logic              din_vld_i,
    output logic [UNARY-1:0]  unary_o,
    output logic [LSB_W-1:0]  binary_o,
    output logic              out_vld_o
);
    localparam int COL_W  = MSB_W / 2;
    localparam int ROW_W  = MSB_W - COL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;
    localparam int DLY_ST = PIPE_DEPTH - 1;

    typedef struct packed {
        logic [UNARY-1:0] unary;
        logic [LSB_W-1:0] bin;
        logic             vld;
    } out_t;

    logic [ROWS-1:0]   row_gt, row_eq;
    logic [COLS-1:0]   col_gt;
    logic [UNARY-1:0]  therm;
    logic [LSB_W-1:0]  lsb_dly;
    logic [DLY_ST-1:0] stage_vld;
    out_t              out_d, out_q;

    seg_msb_predecode #(.MSB_W(MSB_W)) u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .msb_i    (din_i[DATA_W-1 -: MSB_W]),
        .vld_i    (din_vld_i),
        .row_gt_o (row_gt),
        .row_eq_o (row_eq),
        .col_gt_o (col_gt)
    );

    seg_unary_merge #(.ROWS(ROWS), .COLS(COLS)) u_merge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .row_gt_i (row_gt),
        .row_eq_i (row_eq),
        .col_gt_i (col_gt),
        .vld_i    (stage_vld[0]),
        .therm_o  (therm)
    );

    seg_delay_line #(.WIDTH(LSB_W), .STAGES(DLY_ST)) u_lsb_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .dat_i  (din_i[LSB_W-1:0]),
        .vld_i  (din_vld_i),
        .dat_o  (lsb_dly),
        .vld_o  (stage_vld)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = stage_vld[DLY_ST-1];
        if (stage_vld[DLY_ST-1]) begin
            out_d.unary = therm;
            out_d.bin   = lsb_dly;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign unary_o   = out_q.unary;
    assign binary_o  = out_q.bin;
    assign out_vld_o = out_q.vld;
endmodule

// File: rtl/dac_seg_decoder_chk.sv
module dac_seg_decoder_chk #(
    parameter int MSB_W = 6,
    parameter int LSB_W = 6
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [MSB_W+LSB_W-1:0]   din_i,
    input logic                     din_vld_i,
    input logic [(1<<MSB_W)-2:0]    unary_o,
    input logic [LSB_W-1:0]         binary_o,
    input logic                     out_vld_o
);
    localparam int UNARY = (1 << MSB_W) - 1;
    localparam int DATA_W = MSB_W + LSB_W;

    logic [1:0] since_rst;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: output lines always form a thermometer filling from bit 0
    a_r2_thermo_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((({1'b0, unary_o}) + (UNARY+1)'(1)) & {1'b0, unary_o}) == '0);

    // R2: number of enabled cells equals the upper field of the sample
    a_r2_ones_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst == 2'd3 && out_vld_o) |->
            $countones(unary_o) == int'($past(din_i[DATA_W-1 -: MSB_W], 3)));

    // R3: valid reaches the output three registers later
    a_r3_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst == 2'd3) |-> out_vld_o == $past(din_vld_i, 3));

    // R4: binary lines carry the lower field with the same latency
    a_r4_binary_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst == 2'd3 && out_vld_o) |-> binary_o == $past(din_i[LSB_W-1:0], 3));

    // R5: outputs hold when no new sample was loaded
    a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst != 2'd0 && !out_vld_o) |-> ($stable(unary_o) && $stable(binary_o)));
endmodule

bind dac_seg_decoder dac_seg_decoder_chk #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .din_i     (din_i),
    .din_vld_i (din_vld_i),
    .unary_o   (unary_o),
    .binary_o  (binary_o),
    .out_vld_o (out_vld_o)
);

// File: tb/tb_dac_seg_decoder.sv
module tb_dac_seg_decoder;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [11:0] din_i = '0;
    logic        din_vld_i = 1'b0;
    logic [62:0] unary_o;
    logic [5:0]  binary_o;
    logic        out_vld_o;

    int n_checks = 0;
    int n_fails  = 0;

    logic [11:0] h1_d = '0, h2_d = '0;
    logic        h1_v = 1'b0, h2_v = 1'b0;
    logic [62:0] exp_u = '0;
    logic [5:0]  exp_b = '0;
    logic        exp_v = 1'b0;

    always #2.5 clk_i = ~clk_i;

    dac_seg_decoder dut (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .din_i     (din_i),
        .din_vld_i (din_vld_i),
        .unary_o   (unary_o),
        .binary_o  (binary_o),
        .out_vld_o (out_vld_o)
    );

    function automatic logic [62:0] therm_of(input logic [5:0] n);
        logic [63:0] t;
        t = (64'd1 << n) - 64'd1;
        return t[62:0];
    endfunction

    task automatic check_outputs(input string tag);
        string rq;
        n_checks++;
        if (out_vld_o !== exp_v) begin
            n_fails++;
            $display("FAIL R3 %s: out_vld_o=%0b expected %0b", tag, out_vld_o, exp_v);
        end
        rq = exp_v ? "R2" : "R5";
        n_checks++;
        if (unary_o !== exp_u) begin
            n_fails++;
            $display("FAIL %s %s: unary_o=%h expected %h", rq, tag, unary_o, exp_u);
        end
        rq = exp_v ? "R4" : "R5";
        n_checks++;
        if (binary_o !== exp_b) begin
            n_fails++;
            $display("FAIL %s %s: binary_o=%h expected %h", rq, tag, binary_o, exp_b);
        end
    endtask

    // drive one sample, let one rising edge pass, update model, check at falling edge
    task automatic step(input logic v, input logic [11:0] d, input string tag);
        din_vld_i = v;
        din_i     = d;
        @(posedge clk_i);
        exp_v = h2_v;
        if (h2_v) begin
            exp_u = therm_of(h2_d[11:6]);
            exp_b = h2_d[5:0];
        end
        h2_v = h1_v; h2_d = h1_d;
        h1_v = v;    h1_d = d;
        @(negedge clk_i);
        check_outputs(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        n_fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk_i);
        // R1: reset state
        check_outputs("R1 reset");
        rst_ni = 1'b1;

        // R6: minimum code, then maximum code, each followed by idle
        step(1'b1, 12'h000, "R6 min");
        step(1'b0, 12'hABC, "R6 idle");
        step(1'b0, 12'h123, "R6 idle");
        n_checks++;
        if (unary_o !== '0 || binary_o !== '0) begin
            n_fails++;
            $display("FAIL R6 min code: unary_o=%h binary_o=%h expected 0 0", unary_o, binary_o);
        end
        step(1'b1, 12'hFFF, "R6 max");
        step(1'b0, 12'h000, "R6 idle");
        step(1'b0, 12'h000, "R6 idle");
        n_checks++;
        if (unary_o !== {63{1'b1}} || binary_o !== 6'h3F) begin
            n_fails++;
            $display("FAIL R6 max code: unary_o=%h binary_o=%h expected all ones 3f", unary_o, binary_o);
        end

        // R7: every code back to back, ascending
        for (int i = 0; i < 4096; i++) step(1'b1, 12'(i), "R7 sweep");
        // R5: idle with changing data must hold the last sample (0xFFF)
        for (int i = 0; i < 8; i++) step(1'b0, 12'(i * 517), "R5 hold");

        // R5/R7: gated stream with a pseudo-random valid pattern
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[3], lfsr[11:0] ^ 12'(i), "R5 gated");
        end
        for (int i = 0; i < 4; i++) step(1'b0, 12'h5A5, "R3 drain");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule